// File: doc/BRIEF.md
# Constant-Schedule Ladder Exponentiation Sequencer

This block computes `result = msg^e mod n` by the powering ladder. It holds two working values, `A` (starting at 1) and `B` (starting at the message). It walks the exponent from its most significant bit down to bit 0. For every bit it sends one general product `A·B` to a product unit and one squaring to a square unit, in the same cycle. Only the way the two returned values are written back depends on the bit. Every bit therefore costs the same work, and a run's length depends only on its bit count. The modulus lives inside the two external units. The sequencer never sees it.

A run begins on `start` while the block is idle. The exponent length `exp_bits` selects how many low bits of `exp_d` are scanned. In blinded mode the exponent actually scanned is `exp_d + blind_r·phi`, where `phi` is the group order of the modulus and `blind_r` is one random word. For a message coprime to the modulus this gives the same result, at the cost of `WW` extra ladder steps.

Both unit channels are valid/ready on request and on response. A request stays valid, with stable operands, until the unit takes it. The sequencer raises its response `ready` only while it waits for that unit's result, so a unit may finish early and hold its answer. The product unit and the square unit may finish in different cycles. A small fixed-latency modular multiplier, `lm_modmul`, is provided to drive the channels in the testbench.

Top module: `lm_ladder_exp`

## Requirements
- R1: After reset `busy`, `done`, `mul_req_valid` and `sq_req_valid` are 0.
- R2: `start` is accepted only while `busy` is 0. A `start` pulse during a run changes neither that run's result nor its duration.
- R3: Each ladder step raises both request channels in the same cycle. The product unit receives `(A, B)`. The square unit receives the operand `B` if the current exponent bit is 1 and `A` if it is 0, on both of its inputs.
- R4: When the bit is 1, `A` takes the product and `B` takes the square. When the bit is 0, `B` takes the product and `A` takes the square. Both are written in one cycle, only after both responses have been captured, and `A` and `B` hold at all other times outside a load.
- R5: The exponent is scanned MSB first over `min(exp_bits, EW)` bits. Bits of `exp_d` and `phi` at and above that length are ignored.
- R6: `done` is a one-cycle pulse and is followed by idle. `result` equals `A` after the last step, which is `msg^e mod n`, and holds until the next accepted `start`.
- R7: A length of 0 gives `result = 1` with no unit request.
- R8: With `blind_en` set at `start`, the scanned exponent is `e = d + blind_r·phi` over `kc + WW` bits, where `kc = min(exp_bits, EW)`. For a message coprime to n the result equals `msg^d mod n`.
- R9: With fixed-latency units, the cycle count from `start` to `done` depends only on the step count, and not on the exponent value or the message.
- R10: A request holds `valid` with stable operands until `ready`. A response is taken only while its channel awaits one.
- R11: A unit's response is held if it arrives before the other unit's response, and nothing is committed until both have been captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (taken when idle) |
| blind_en | input | 1 | Blind the exponent for this run |
| msg | input | DW | Message (base) |
| exp_d | input | EW | Exponent |
| exp_bits | input | KW | Exponent bit length, clamped to EW |
| phi | input | EW | Group order used for blinding |
| blind_r | input | WW | Blinding word |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Final value |
| mul_req_valid | output | 1 | Product request valid |
| mul_req_ready | input | 1 | Product unit takes request |
| mul_req_a | output | DW | Product operand A |
| mul_req_b | output | DW | Product operand B |
| mul_rsp_valid | input | 1 | Product result valid |
| mul_rsp_ready | output | 1 | Sequencer awaits product |
| mul_rsp_data | input | DW | Product result |
| sq_req_valid | output | 1 | Square request valid |
| sq_req_ready | input | 1 | Square unit takes request |
| sq_req_a | output | DW | Square operand |
| sq_req_b | output | DW | Square operand (copy) |
| sq_rsp_valid | input | 1 | Square result valid |
| sq_rsp_ready | output | 1 | Sequencer awaits square |
| sq_rsp_data | input | DW | Square result |

## Verification
The hardest situation to reach is two responses that arrive in different cycles, where the earlier one must be parked without being lost or committed alone. The bench gets there by giving the product and square units unequal fixed latencies, so that every step runs through this skew. A second hard case is a blinded exponent whose extra steps must still reproduce the unblinded result. This is reached by choosing small moduli with known group order and coprime messages, then comparing the blinded result against direct exponentiation by the bare exponent. Run-length independence is shown by pairing runs of equal step count that have different exponents, different modes and a start pulse injected mid-run.

// File: rtl/lm_pkg.sv
package lm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } lm_state_e;

  localparam int CH_MUL = 0;
  localparam int CH_SQR = 1;
  localparam int N_CH   = 2;
endpackage

// File: rtl/lm_exp_blinder.sv
module lm_exp_blinder #(
  parameter int EW = 16,
  parameter int WW = 8,
  localparam int KW = $clog2(EW + 1),
  localparam int XW = EW + WW,
  localparam int SW = $clog2(XW + 1)
) (
  input  logic [EW-1:0] exp_d,
  input  logic [EW-1:0] phi,
  input  logic [WW-1:0] blind_r,
  input  logic [KW-1:0] exp_bits,
  input  logic          blind_en,
  output logic [XW-1:0] exp_x,
  output logic [SW-1:0] steps
);
  localparam logic [KW-1:0] KMAX = KW'(EW);

  logic [KW-1:0] kc;
  logic [EW-1:0] kmask;
  logic [EW-1:0] d_m;
  logic [EW-1:0] p_m;
  logic [XW-1:0] rp;

  assign kc = (exp_bits > KMAX) ? KMAX : exp_bits;

  always_comb begin
    for (int i = 0; i < EW; i++) kmask[i] = (int'(kc) > i);
  end

  assign d_m   = exp_d & kmask;
  assign p_m   = phi & kmask;
  assign rp    = XW'(blind_r) * XW'(p_m);
  assign exp_x = blind_en ? (XW'(d_m) + rp) : XW'(d_m);
  assign steps = SW'(kc) + (blind_en ? SW'(WW) : SW'(0));
endmodule

// File: rtl/lm_mul_port.sv
module lm_mul_port #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic          take,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_a,
  output logic [DW-1:0] req_b,
  input  logic          rsp_valid,
  output logic          rsp_ready,
  input  logic [DW-1:0] rsp_data,
  output logic          have,
  output logic [DW-1:0] prod
);
  logic waiting;

  assign rsp_ready = waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_a     <= '0;
      req_b     <= '0;
      waiting   <= 1'b0;
      have      <= 1'b0;
      prod      <= '0;
    end else begin
      if (issue) begin
        req_valid <= 1'b1;
        req_a     <= op_a;
        req_b     <= op_b;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (req_valid && req_ready) waiting <= 1'b1;
      else if (rsp_valid && waiting) waiting <= 1'b0;
      if (rsp_valid && waiting) begin
        have <= 1'b1;
        prod <= rsp_data;
      end else if (take) begin
        have <= 1'b0;
      end
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_a) && $stable(req_b)));

  assert_issue_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (!req_valid && !waiting && !have));

  assert_take_after_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> have);
endmodule

// File: rtl/lm_ladder_regs.sv
module lm_ladder_regs #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] msg,
  input  logic          commit,
  input  logic          bit_val,
  input  logic [DW-1:0] prod_in,
  input  logic [DW-1:0] sqr_in,
  output logic [DW-1:0] reg_a,
  output logic [DW-1:0] reg_b,
  output logic [DW-1:0] sq_op
);
  assign sq_op = bit_val ? reg_b : reg_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a <= '0;
      reg_b <= '0;
    end else if (load) begin
      reg_a <= DW'(1);
      reg_b <= msg;
    end else if (commit) begin
      if (bit_val) begin
        reg_a <= prod_in;
        reg_b <= sqr_in;
      end else begin
        reg_b <= prod_in;
        reg_a <= sqr_in;
      end
    end
  end

  assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !commit) |=> ($stable(reg_a) && $stable(reg_b)));
endmodule

// File: rtl/lm_modmul.sv
module lm_modmul #(
  parameter int DW  = 16,
  parameter int LAT = 3,
  localparam int CW = $clog2(LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] modulus,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_a,
  input  logic [DW-1:0] req_b,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);
  logic [CW-1:0] cnt;
  logic          working;
  logic [DW-1:0] res;

  assign req_ready = !working && !rsp_valid;
  assign res = DW'(({{DW{1'b0}}, req_a} * {{DW{1'b0}}, req_b}) % {{DW{1'b0}}, modulus});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      working   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (req_valid && req_ready) begin
        rsp_data <= res;
        working  <= 1'b1;
        cnt      <= CW'(LAT - 1);
      end else if (working) begin
        if (cnt == '0) begin
          working   <= 1'b0;
          rsp_valid <= 1'b1;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

// File: rtl/lm_ladder_exp.sv
module lm_ladder_exp
  import lm_pkg::*;
#(
  parameter int DW = 16,
  parameter int EW = 16,
  parameter int WW = 8,
  localparam int KW = $clog2(EW + 1),
  localparam int XW = EW + WW,
  localparam int SW = $clog2(XW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          blind_en,
  input  logic [DW-1:0] msg,
  input  logic [EW-1:0] exp_d,
  input  logic [KW-1:0] exp_bits,
  input  logic [EW-1:0] phi,
  input  logic [WW-1:0] blind_r,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          mul_req_valid,
  input  logic          mul_req_ready,
  output logic [DW-1:0] mul_req_a,
  output logic [DW-1:0] mul_req_b,
  input  logic          mul_rsp_valid,
  output logic          mul_rsp_ready,
  input  logic [DW-1:0] mul_rsp_data,
  output logic          sq_req_valid,
  input  logic          sq_req_ready,
  output logic [DW-1:0] sq_req_a,
  output logic [DW-1:0] sq_req_b,
  input  logic          sq_rsp_valid,
  output logic          sq_rsp_ready,
  input  logic [DW-1:0] sq_rsp_data
);
  lm_state_e     st;
  logic [XW-1:0] dreg;
  logic [SW-1:0] cnt;
  logic [XW-1:0] exp_x;
  logic [SW-1:0] steps;
  logic          load, issue, commit, bit_val;
  logic [DW-1:0] reg_a, reg_b, sq_op;

  logic [DW-1:0] op_a [N_CH];
  logic [DW-1:0] op_b [N_CH];
  logic [DW-1:0] q_a  [N_CH];
  logic [DW-1:0] q_b  [N_CH];
  logic [DW-1:0] r_d  [N_CH];
  logic [DW-1:0] prod [N_CH];
  logic [N_CH-1:0] q_v, q_r, r_v, r_r, have;

  lm_exp_blinder #(.EW(EW), .WW(WW)) u_blind (
    .exp_d(exp_d), .phi(phi), .blind_r(blind_r), .exp_bits(exp_bits),
    .blind_en(blind_en), .exp_x(exp_x), .steps(steps)
  );

  assign load    = (st == ST_IDLE) && start;
  assign issue   = (st == ST_ISSUE);
  assign commit  = (st == ST_WAIT) && (&have);
  assign bit_val = dreg[XW-1];

  lm_ladder_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .load(load), .msg(msg), .commit(commit),
    .bit_val(bit_val), .prod_in(prod[CH_MUL]), .sqr_in(prod[CH_SQR]),
    .reg_a(reg_a), .reg_b(reg_b), .sq_op(sq_op)
  );

  assign op_a[CH_MUL] = reg_a;
  assign op_b[CH_MUL] = reg_b;
  assign op_a[CH_SQR] = sq_op;
  assign op_b[CH_SQR] = sq_op;

  assign q_r = {sq_req_ready, mul_req_ready};
  assign r_v = {sq_rsp_valid, mul_rsp_valid};
  assign r_d[CH_MUL] = mul_rsp_data;
  assign r_d[CH_SQR] = sq_rsp_data;

  for (genvar g = 0; g < N_CH; g++) begin : g_port
    lm_mul_port #(.DW(DW)) u_port (
      .clk(clk), .rst_n(rst_n), .issue(issue), .op_a(op_a[g]), .op_b(op_b[g]),
      .take(commit), .req_valid(q_v[g]), .req_ready(q_r[g]), .req_a(q_a[g]),
      .req_b(q_b[g]), .rsp_valid(r_v[g]), .rsp_ready(r_r[g]), .rsp_data(r_d[g]),
      .have(have[g]), .prod(prod[g])
    );
  end

  assign mul_req_valid = q_v[CH_MUL];
  assign mul_req_a     = q_a[CH_MUL];
  assign mul_req_b     = q_b[CH_MUL];
  assign mul_rsp_ready = r_r[CH_MUL];
  assign sq_req_valid  = q_v[CH_SQR];
  assign sq_req_a      = q_a[CH_SQR];
  assign sq_req_b      = q_b[CH_SQR];
  assign sq_rsp_ready  = r_r[CH_SQR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      dreg <= '0;
      cnt  <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          dreg <= exp_x << (SW'(XW) - steps);
          cnt  <= steps;
          st   <= (steps == '0) ? ST_FIN : ST_ISSUE;
        end
        ST_ISSUE: st <= ST_WAIT;
        ST_WAIT: if (commit) begin
          dreg <= dreg << 1;
          cnt  <= cnt - 1'b1;
          st   <= (cnt == SW'(1)) ? ST_FIN : ST_ISSUE;
        end
        ST_FIN: st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (st != ST_IDLE);
  assign done   = (st == ST_FIN);
  assign result = reg_a;

  assert_start_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  assert_pair_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mul_req_valid) |-> $rose(sq_req_valid));

  assert_steps_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ISSUE || st == ST_WAIT) |-> (cnt != '0));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

// File: tb/lm_ladder_exp_test.sv
module lm_ladder_exp_test;
  localparam int DW = 16;
  localparam int EW = 16;
  localparam int WW = 8;
  localparam int KW = $clog2(EW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start = 1'b0, blind_en = 1'b0;
  logic [DW-1:0] msg = '0, nmod = 16'd143;
  logic [EW-1:0] exp_d = '0, phi = '0;
  logic [KW-1:0] exp_bits = '0;
  logic [WW-1:0] blind_r = '0;
  logic          busy, done;
  logic [DW-1:0] result;
  logic          mqv, mqr, mrv, mrr, sqv, sqr, srv, srr;
  logic [DW-1:0] mqa, mqb, mrd, sqa, sqb, srd;

  lm_ladder_exp #(.DW(DW), .EW(EW), .WW(WW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blind_en(blind_en), .msg(msg),
    .exp_d(exp_d), .exp_bits(exp_bits), .phi(phi), .blind_r(blind_r),
    .busy(busy), .done(done), .result(result),
    .mul_req_valid(mqv), .mul_req_ready(mqr), .mul_req_a(mqa), .mul_req_b(mqb),
    .mul_rsp_valid(mrv), .mul_rsp_ready(mrr), .mul_rsp_data(mrd),
    .sq_req_valid(sqv), .sq_req_ready(sqr), .sq_req_a(sqa), .sq_req_b(sqb),
    .sq_rsp_valid(srv), .sq_rsp_ready(srr), .sq_rsp_data(srd)
  );

  lm_modmul #(.DW(DW), .LAT(3)) u_pmul (
    .clk(clk), .rst_n(rst_n), .modulus(nmod), .req_valid(mqv), .req_ready(mqr),
    .req_a(mqa), .req_b(mqb), .rsp_valid(mrv), .rsp_ready(mrr), .rsp_data(mrd)
  );
  lm_modmul #(.DW(DW), .LAT(5)) u_smul (
    .clk(clk), .rst_n(rst_n), .modulus(nmod), .req_valid(sqv), .req_ready(sqr),
    .req_a(sqa), .req_b(sqb), .rsp_valid(srv), .rsp_ready(srr), .rsp_data(srd)
  );

  int checks = 0, failures = 0;
  bit reported = 0;
  longint ma, mb, mdx, msteps;
  int mj;
  bit seen_m, seen_s;
  longint sq_e;
  bit sq_bit;
  int cyc_tab [int];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  function automatic longint modpow(longint b, longint e, longint n);
    longint acc = 1, x = b % n, k = e;
    while (k != 0) begin
      if (k[0]) acc = (acc * x) % n;
      x = (x * x) % n;
      k = k >> 1;
    end
    return acc % n;
  endfunction

  // Per-clock reference model of the ladder (R3, R4, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (mqv && mqr) begin
        chk(longint'(mqa) == ma && longint'(mqb) == mb, "R3 product operands", longint'(mqa), ma);
        chk(sqv && sqr, "R3 square request in same cycle", longint'(sqv && sqr), 1);
        seen_m = 1;
      end
      if (sqv && sqr) begin
        sq_bit = mj >= 0 ? mdx[mj] : 1'b0;
        sq_e = sq_bit ? mb : ma;
        chk(longint'(sqa) == sq_e && longint'(sqb) == sq_e, "R3 square operand", longint'(sqa), sq_e);
        seen_s = 1;
      end
      if (seen_m && seen_s) begin
        longint p, s;
        p = (ma * mb) % longint'(nmod);
        s = (sq_e * sq_e) % longint'(nmod);
        if (sq_bit) begin ma = p; mb = s; end
        else begin mb = p; ma = s; end
        mj--;
        msteps++;
        seen_m = 0;
        seen_s = 0;
      end
    end
  end

  task automatic run(input longint m, input longint d, input int k, input bit bl,
                     input longint r, input longint ph, input int poke, input string tag);
    int kc, K, cyc;
    longint mask, dm, pm;
    kc = (k > EW) ? EW : k;
    mask = (longint'(1) << kc) - 1;
    dm = d & mask;
    pm = ph & mask;
    @(negedge clk);
    chk(!busy, {tag, " R2 idle before start"}, longint'(busy), 0);
    msg = DW'(m); exp_d = EW'(d); exp_bits = KW'(k); blind_en = bl;
    blind_r = WW'(r); phi = EW'(ph); start = 1'b1;
    mdx = bl ? dm + r * pm : dm;
    K = kc + (bl ? WW : 0);
    ma = 1; mb = m; mj = K - 1; msteps = 0; seen_m = 0; seen_s = 0;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
      start = (cyc == poke);
      if (cyc == poke) begin msg = DW'(m + 1); exp_d = ~EW'(d); end
    end while (!done && cyc < 5000);
    start = 1'b0;
    chk(done, {tag, " R6 done reached"}, longint'(done), 1);
    chk(longint'(result) == ma, {tag, " R4 result equals model"}, longint'(result), ma);
    chk(longint'(result) == modpow(m, mdx, nmod), {tag, " R6 result"}, longint'(result), modpow(m, mdx, nmod));
    chk(msteps == K, {tag, " R5 step count"}, msteps, K);
    if (bl) chk(longint'(result) == modpow(m, dm, nmod), {tag, " R8 blinded equals bare"},
                longint'(result), modpow(m, dm, nmod));
    if (cyc_tab.exists(K)) chk(cyc == cyc_tab[K], {tag, " R9 fixed duration"}, cyc, cyc_tab[K]);
    else cyc_tab[K] = cyc;
    @(negedge clk);
    chk(!done && !busy, {tag, " R6 single pulse"}, longint'(done), 0);
    chk(longint'(result) == ma, {tag, " R6 result held"}, longint'(result), ma);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mqv && !sqv, "R1 reset state", longint'({busy, done, mqv, sqv}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mqv && !sqv, "R1 idle after reset", longint'({busy, done, mqv, sqv}), 0);

    nmod = 16'd143;
    run(5, 'hB7, 8, 0, 0, 0, 0, "R6 basic");
    run(7, 'h5A, 8, 0, 0, 0, 0, "R9 other exponent");
    run(2, 'hFF, 8, 0, 0, 0, 0, "R3 all ones");
    run(3, 'hFFF3, 4, 0, 0, 0, 0, "R5 high bits ignored");
    run(9, 'h1234, 0, 0, 0, 0, 0, "R7 zero length");
    chk(result == 16'd1, "R7 result one", longint'(result), 1);
    run(5, 'hB7, 8, 1, 'h5D, 120, 0, "R8 blinded");
    run(9, 'h1234, 16, 0, 0, 0, 0, "R9 same steps as blinded");
    run(4, 'hABCD, 20, 0, 0, 0, 0, "R5 length clamp");
    run(6, 'h9C, 8, 0, 0, 0, 10, "R2 start while busy");
    run(10, 'h2D, 8, 1, 0, 120, 0, "R8 zero blind word");
    nmod = 16'd3233;
    run(65, 17, 12, 1, 'hC3, 3120, 0, "R8 larger modulus");
    chk(result == 16'd2790, "R8 known value", longint'(result), 2790);
    run(123, 2753, 12, 0, 0, 0, 0, "R11 skewed units");
    report();
    $finish;
  end
endmodule